// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Controller

This block collects a set of level-sensitive interrupt request lines from local-bus peripherals. It captures them into a source register and qualifies them with an enable mask written by software. Any qualified request drives a single combined interrupt output towards the processor. Software does not have to scan the raw request bits. It reads a vector word that names the lowest-numbered qualified line directly: the line number plus one, scaled by four, so it can be used as a word index into a dispatch table. A value of zero means nothing is pending.

Software uses a 16-bit register port with two word locations: the vector word and the enable mask. The mask comes out of reset with a single line enabled. Edge capture, acknowledge cycles and nesting are not part of this block.

Top module: `irq_mask_ctrl`

## Requirements
- R1: Each request line is sampled on every rising clock edge into the source register. A line that is high sets its source bit, and a line that is low clears it.
- R2: The combined output `irqOut` is high exactly when the source bits ANDed with the enable mask are non-zero. It is registered, so a change on a line or in the mask shows on `irqOut` after one rising edge. While every request line is low, `irqOut` is low on the following cycle.
- R3: A read with `regWord` = 0 (byte offset 0x0) returns ((n + 1) << 2), where n is the selected pending line. It returns zero when no line is pending. Bits [1:0] of this value are always zero.
- R4: When more than one line is pending, the selected line n is the lowest-numbered one.
- R5: A read with `regWord` = 1 (byte offset 0x2) returns the enable mask, with bit i enabling line i. A write with `regWord` = 1 replaces all 16 mask bits, and the new mask governs `irqOut` from the next edge on.
- R6: A write with `regWord` = 0 changes neither the mask nor the source register nor `irqOut`.
- R7: After reset the mask reads 0x0010, the source register is zero and `irqOut` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLines | input | 16 | Level-sensitive request lines, bit i is line i |
| regWord | input | 1 | Word select: 0 for the vector word at 0x0, 1 for the mask at 0x2 |
| regWr | input | 1 | Write strobe for the selected word |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data of the selected word, combinational |
| irqOut | output | 1 | Combined masked interrupt request, registered |

## Verification
The bench builds the block with its default parameters: 16 lines, a 16-bit port and a shift of two for the vector. This is small enough to drive every single-line request under six mask patterns, including all-clear, all-set and alternating masks. Beyond those, 64 pseudo-random multi-line patterns per mask cover lowest-line priority with arbitrary line combinations. The bench also checks the extreme vector values 0x4 and 0x40, and that a mask write takes effect one edge later.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  // Strobes from the access decoder to the register datapath
  typedef struct packed {
    logic loadMask;  // replace the enable mask this edge
    logic selMask;   // drive the mask onto the read bus
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_mask_ctrl_dec.sv
module irq_mask_ctrl_dec
  import irq_mask_pkg::*;
(
  input  logic        regWord,
  input  logic        regWr,
  output ctrlStrobe_t strobe
);
  // Word 1 holds the mask; word 0 is read-only (vector), so writes there are dropped.
  always_comb begin
    strobe.loadMask = regWr & regWord;
    strobe.selMask  = regWord;
  end
endmodule

// File: rtl/irq_mask_dp.sv
module irq_mask_dp
  import irq_mask_pkg::*;
#(
  parameter int          NUM_LINES = 16,
  parameter int          DATA_W    = 16,
  parameter int          VEC_SHIFT = 2,
  parameter logic [15:0] MASK_RST  = 16'h0010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic [DATA_W-1:0]    regWrData,
  input  ctrlStrobe_t          strobe,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 irqOut
);
  localparam logic [NUM_LINES-1:0] MASK_INIT = NUM_LINES'(MASK_RST);

  logic [NUM_LINES-1:0] srcQ;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] maskNext;
  logic [NUM_LINES-1:0] pending;
  logic                 irqQ;
  logic [DATA_W-1:0]    vecWord;

  assign maskNext = strobe.loadMask ? regWrData[NUM_LINES-1:0] : maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ  <= '0;
      maskQ <= MASK_INIT;
      irqQ  <= 1'b0;
    end else begin
      srcQ  <= irqLines;
      maskQ <= maskNext;
      irqQ  <= |(irqLines & maskNext);
    end
  end

  assign pending = srcQ & maskQ;

  // Lowest-numbered pending line wins: scan downward so the last hit is the lowest.
  always_comb begin
    vecWord = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pending[i]) vecWord = DATA_W'(i + 1) << VEC_SHIFT;
    end
  end

  assign regRdData = strobe.selMask ? DATA_W'(maskQ) : vecWord;
  assign irqOut    = irqQ;
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int          NUM_LINES = 16,
  parameter int          DATA_W    = 16,
  parameter int          VEC_SHIFT = 2,
  parameter logic [15:0] MASK_RST  = 16'h0010
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 regWord,
  input  logic                 regWr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 irqOut
);
  ctrlStrobe_t strobe;

  irq_mask_ctrl_dec u_dec (
    .regWord (regWord),
    .regWr   (regWr),
    .strobe  (strobe)
  );

  irq_mask_dp #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .VEC_SHIFT (VEC_SHIFT),
    .MASK_RST  (MASK_RST)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .irqLines  (irqLines),
    .regWrData (regWrData),
    .strobe    (strobe),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] irqLines,
  input logic                 regWord,
  input logic                 regWr,
  input logic [DATA_W-1:0]    regWrData,
  input logic [DATA_W-1:0]    regRdData,
  input logic                 irqOut
);
  // R2
  irq_vec_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWord |-> (irqOut == (regRdData != '0)));

  // R3
  vec_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWord |-> (regRdData[1:0] == 2'b00));

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regWord) |=> (!regWord || regRdData == $past(regWrData)));

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqLines == '0) |=> !irqOut);

  // R7
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !irqOut);
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .DATA_W    (DATA_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqLines  (irqLines),
  .regWord   (regWord),
  .regWr     (regWr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .irqOut    (irqOut)
);

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqLines = '0;
  logic        regWord = 1'b0;
  logic        regWr = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqOut;

  int vecCount = 0;
  int failCount = 0;
  logic [15:0] expMask = 16'h0010;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_mask_ctrl u_irq_mask_ctrl (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regWord(regWord),
    .regWr(regWr), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expVec(logic [15:0] lines, logic [15:0] mask);
    logic [15:0] p = lines & mask;
    for (int i = 0; i < 16; i++) if (p[i]) return 16'((i + 1) * 4);
    return 16'h0;
  endfunction

  // drive lines, let one edge pass, then check output and vector (R1 R2 R3 R4)
  task automatic applyLines(logic [15:0] v, string req);
    @(negedge clk);
    irqLines = v;
    regWord  = 1'b0;
    @(negedge clk);
    check({req, " irq"}, {15'h0, irqOut}, {15'h0, |(v & expMask)});
    check({req, " vector"}, regRdData, expVec(v, expMask));
  endtask

  task automatic writeWord(logic word, logic [15:0] d);
    @(negedge clk);
    regWord = word; regWr = 1'b1; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  initial begin
    // R7 reset state
    irqLines = 16'h0010;
    repeat (3) @(negedge clk);
    check("R7 irq in reset", {15'h0, irqOut}, 16'h0);
    rstN = 1'b1;
    irqLines = '0;
    regWord = 1'b1;
    #1;
    check("R7 mask reset", regRdData, 16'h0010);
    regWord = 1'b0;
    #1;
    check("R7 source reset", regRdData, 16'h0000);
    check("R7 irq after reset", {15'h0, irqOut}, 16'h0);

    // R5 mask write, then R2 timing of a mask change
    applyLines(16'h0020, "R2 masked-off line");
    writeWord(1'b1, 16'h0020);
    expMask = 16'h0020;
    regWord = 1'b1;
    #1;
    check("R5 mask readback", regRdData, 16'h0020);
    regWord = 1'b0;
    #1;
    check("R5 mask enables held line", {15'h0, irqOut}, 16'h1);
    check("R5 vector after mask", regRdData, 16'd24);

    // R6 write to vector word ignored
    writeWord(1'b0, 16'hFFFF);
    regWord = 1'b0;
    #1;
    check("R6 vector unchanged", regRdData, 16'd24);
    check("R6 irq unchanged", {15'h0, irqOut}, 16'h1);
    regWord = 1'b1;
    #1;
    check("R6 mask unchanged", regRdData, 16'h0020);

    // R4 explicit priority corners
    writeWord(1'b1, 16'hFFFF);
    expMask = 16'hFFFF;
    applyLines(16'hFFFF, "R4 all lines");
    check("R4 line0 wins", regRdData, 16'h0004);
    applyLines(16'h8100, "R4 lines 8 and 15");
    check("R4 line8 wins", regRdData, 16'd36);
    applyLines(16'h8000, "R3 top line");
    check("R3 top vector", regRdData, 16'h0040);

    // near-exhaustive sweep (R1 R2 R3 R4 R5)
    foreach (expMask[k]) ;
    for (int m = 0; m < 6; m++) begin
      logic [15:0] mk;
      case (m)
        0: mk = 16'h0010;
        1: mk = 16'hFFFF;
        2: mk = 16'h0000;
        3: mk = 16'hA5A5;
        4: mk = 16'h5A5A;
        default: mk = 16'h8001;
      endcase
      writeWord(1'b1, mk);
      expMask = mk;
      for (int n = 0; n < 16; n++) applyLines(16'h1 << n, "R1 single line");
      for (int r = 0; r < 64; r++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        applyLines(lfsr, "R4 multi line");
      end
      applyLines(16'h0000, "R2 idle");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failCount++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule